// File: doc/BRIEF.md
# Thread Block Warp Splitter

This block takes one thread-block descriptor at a time, a block identifier and a thread count, and turns it into a stream of warp descriptors. Each warp descriptor carries the block identifier, the ID of the warp's first thread, and a mask with one bit per lane. A lane bit is set when that lane holds a real thread.

Warps are cut in a fixed order. The first warp starts at thread 0, and each next warp starts exactly `WARP_SIZE` threads later. No warp ever holds threads of two blocks. When the thread count is not a whole multiple of the warp size, the last warp is filled up with masked-off dummy lanes. The last warp of a block is also flagged.

Both sides use a valid/ready handshake. A new block is taken only once the final warp of the current block has been handed off. That can happen in the same cycle as the handoff. A block with zero threads is taken at once and yields no warps.

Top module: `warp_splitter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wrp_valid` is 0 and `blk_ready` is 1.
- R2: The first warp emitted for a block has `wrp_base` equal to 0 and `wrp_block` equal to the accepted block identifier.
- R3: Each following warp of the same block has `wrp_base` larger by exactly `WARP_SIZE` than the warp before it, and it has the same `wrp_block`.
- R4: Bit i of `wrp_mask` is 1 exactly when `wrp_base + i` is less than the block's thread count. So every warp except the last has all bits set, and the last warp has its low lanes set and its high dummy lanes cleared.
- R5: A block of N threads (N > 0) yields exactly ceil(N / `WARP_SIZE`) warps. `wrp_last` is 1 on the final warp only.
- R6: A block whose thread count is 0 is accepted in one handshake and yields no warp.
- R7: `blk_ready` is 0 while a block still has warps outstanding. The one exception is the cycle in which its final warp is taken: there `blk_ready` is 1 and a new block may be accepted in that same cycle.
- R8: While `wrp_valid` is 1 and `wrp_ready` is 0, the warp descriptor stays unchanged into the next cycle.
- R9: Two blocks with the same thread count yield the same sequence of bases, masks and last flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Block descriptor offered |
| blk_ready | output | 1 | Splitter can take a block descriptor |
| blk_id | input | BID_W | Block identifier |
| blk_threads | input | CNT_W | Number of threads in the block |
| wrp_valid | output | 1 | Warp descriptor valid |
| wrp_ready | input | 1 | Consumer takes the warp descriptor |
| wrp_block | output | BID_W | Identifier of the block the warp belongs to |
| wrp_base | output | CNT_W | Thread ID held by lane 0 |
| wrp_mask | output | WARP_SIZE | Lane-active mask, bit i for lane i |
| wrp_last | output | 1 | Final warp of the block |

## Verification
Two things can happen in the same cycle: the consumer takes a block's final warp, and the producer hands over the next block. In the second half of the run both handshakes are held permanently high, so each final-warp handoff lines up with a waiting block descriptor. The bench requires that such coincidences actually happened. In those cycles it checks that `blk_ready` is asserted and that the new block's first warp, with base 0 and the new identifier, appears on the very next cycle without an empty cycle between.

// File: rtl/warp_splitter.sv
module warp_splitter #(
  parameter int WARP_SIZE = 32,
  parameter int CNT_W     = 11,
  parameter int BID_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 blk_valid,
  output logic                 blk_ready,
  input  logic [BID_W-1:0]     blk_id,
  input  logic [CNT_W-1:0]     blk_threads,
  output logic                 wrp_valid,
  input  logic                 wrp_ready,
  output logic [BID_W-1:0]     wrp_block,
  output logic [CNT_W-1:0]     wrp_base,
  output logic [WARP_SIZE-1:0] wrp_mask,
  output logic                 wrp_last
);

  localparam int EW = CNT_W + 1;

  logic             busy;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BID_W-1:0] id_q;

  logic [EW-1:0] next_base;
  logic          take;
  logic          accept;

  assign next_base = {1'b0, base_q} + EW'(WARP_SIZE);
  assign wrp_last  = next_base >= {1'b0, cnt_q};
  assign take      = busy & wrp_ready;
  assign blk_ready = ~busy | (take & wrp_last);
  assign accept    = blk_valid & blk_ready;

  assign wrp_valid = busy;
  assign wrp_block = id_q;
  assign wrp_base  = base_q;

  generate
    for (genvar i = 0; i < WARP_SIZE; i++) begin : g_lane
      assign wrp_mask[i] = ({1'b0, base_q} + EW'(i)) < {1'b0, cnt_q};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      id_q   <= '0;
    end else if (accept) begin
      busy   <= blk_threads != '0;
      base_q <= '0;
      cnt_q  <= blk_threads;
      id_q   <= blk_id;
    end else if (take) begin
      if (wrp_last) busy <= 1'b0;
      else          base_q <= next_base[CNT_W-1:0];
    end
  end

  // R4
  lane0_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrp_valid |-> wrp_mask[0]);

  // R4
  full_mid_warp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_valid && !wrp_last) |-> (&wrp_mask));

  // R3
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_valid && wrp_ready && !wrp_last) |=>
      (wrp_valid && wrp_base == $past(wrp_base) + CNT_W'(WARP_SIZE) && $stable(wrp_block)));

  // R8
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_valid && !wrp_ready) |=>
      (wrp_valid && $stable(wrp_base) && $stable(wrp_mask) && $stable(wrp_block) && $stable(wrp_last)));

  // R7
  no_early_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrp_valid && !(wrp_ready && wrp_last)) |-> !blk_ready);

  // R6
  empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready && blk_threads == '0) |=> !wrp_valid);

  // R2
  first_warp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready && blk_threads != '0) |=> (wrp_valid && wrp_base == '0));

endmodule

// File: tb/warp_splitter_tb.sv
module warp_splitter_tb;
  localparam int WS = 8;
  localparam int CW = 8;
  localparam int BW = 6;
  localparam int NB = 48;
  localparam int LIMIT = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_valid = 1'b0;
  logic          blk_ready;
  logic [BW-1:0] blk_id = '0;
  logic [CW-1:0] blk_threads = '0;
  logic          wrp_valid;
  logic          wrp_ready = 1'b0;
  logic [BW-1:0] wrp_block;
  logic [CW-1:0] wrp_base;
  logic [WS-1:0] wrp_mask;
  logic          wrp_last;

  always #5 clk = ~clk;

  warp_splitter #(.WARP_SIZE(WS), .CNT_W(CW), .BID_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_id(blk_id), .blk_threads(blk_threads),
    .wrp_valid(wrp_valid), .wrp_ready(wrp_ready), .wrp_block(wrp_block),
    .wrp_base(wrp_base), .wrp_mask(wrp_mask), .wrp_last(wrp_last)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [WS-1:0] exp_mask(input int base, input int cnt);
    logic [WS-1:0] m;
    for (int i = 0; i < WS; i++) m[i] = (base + i) < cnt;
    return m;
  endfunction

  int cnts[NB];
  int ids[NB];
  int sig[NB];
  int nwarps[NB];

  initial begin
    int bi;
    bit active;
    int cur_idx, cur_base, cur_cnt, cur_id;
    bit took;
    bit stall;
    logic [CW-1:0] s_base; logic [WS-1:0] s_mask; logic [BW-1:0] s_blk; logic s_last;
    int overlaps;
    int cyc;
    bit phase2;
    bit bfire, wfire, exp_last, exp_rdy;
    int seed;

    seed = $urandom(32'd20250);
    cnts[0] = 0;  cnts[1] = 1;  cnts[2] = 19; cnts[3] = 19;
    cnts[4] = 8;  cnts[5] = 9;  cnts[6] = 0;  cnts[7] = 0;
    cnts[8] = 16; cnts[9] = 7;  cnts[10] = 255; cnts[11] = 15;
    for (int k = 12; k < NB; k++) cnts[k] = ($urandom % 5 == 0) ? 0 : int'($urandom % 70);
    for (int k = 0; k < NB; k++) begin ids[k] = (k * 7 + 3) % 64; sig[k] = 0; nwarps[k] = 0; end

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(wrp_valid == 1'b0, "R1 valid in reset", wrp_valid, 0);
    chk(blk_ready == 1'b1, "R1 ready in reset", blk_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wrp_valid == 1'b0, "R1 valid after reset", wrp_valid, 0);
    chk(blk_ready == 1'b1, "R1 ready after reset", blk_ready, 1);

    bi = 0; active = 0; took = 0; stall = 0; overlaps = 0; cyc = 0;
    cur_idx = 0; cur_base = 0; cur_cnt = 0; cur_id = 0;
    while ((bi < NB || active) && cyc < LIMIT) begin
      if (cyc != 0) @(negedge clk);
      cyc++;
      phase2 = bi >= NB / 2;
      if (took) begin blk_valid = 1'b0; took = 0; end
      if (!blk_valid && bi < NB && (phase2 || $urandom % 10 < 7)) begin
        blk_valid = 1'b1; blk_id = BW'(ids[bi]); blk_threads = CW'(cnts[bi]);
      end
      wrp_ready = phase2 ? 1'b1 : ($urandom % 10 < 6);
      #3;
      if (stall) begin
        chk(wrp_valid && wrp_base == s_base && wrp_mask == s_mask && wrp_block == s_blk && wrp_last == s_last,
            "R8 hold", {wrp_block, wrp_base, wrp_mask}, {s_blk, s_base, s_mask});
      end
      chk(wrp_valid == active, "R5 warp count / R6 empty", wrp_valid, active);
      exp_last = active && (cur_base + WS >= cur_cnt);
      exp_rdy = !active || (wrp_ready && exp_last);
      chk(blk_ready == exp_rdy, "R7 block ready", blk_ready, exp_rdy);
      if (active && wrp_valid) begin
        if (cur_base == 0)
          chk(wrp_base == 0 && wrp_block == BW'(cur_id), "R2 first warp", {wrp_block, wrp_base}, {BW'(cur_id), CW'(0)});
        else
          chk(wrp_base == CW'(cur_base) && wrp_block == BW'(cur_id), "R3 next warp", {wrp_block, wrp_base}, {BW'(cur_id), CW'(cur_base)});
        chk(wrp_mask == exp_mask(cur_base, cur_cnt), "R4 mask", wrp_mask, exp_mask(cur_base, cur_cnt));
        chk(wrp_last == exp_last, "R5 last flag", wrp_last, exp_last);
      end
      stall = wrp_valid && !wrp_ready;
      s_base = wrp_base; s_mask = wrp_mask; s_blk = wrp_block; s_last = wrp_last;
      bfire = blk_valid && blk_ready;
      wfire = wrp_valid && wrp_ready;
      if (wfire && active) begin
        sig[cur_idx] = sig[cur_idx] * 31 + int'(wrp_base) * 257 + int'(wrp_mask) + (wrp_last ? 65536 : 0);
        nwarps[cur_idx]++;
        if (exp_last) active = 0; else cur_base += WS;
      end
      if (bfire) begin
        if (wfire && wrp_last) overlaps++;
        cur_idx = bi; cur_base = 0; cur_cnt = cnts[bi]; cur_id = ids[bi];
        active = cnts[bi] != 0;
        bi++; took = 1;
      end
    end

    if (cyc >= LIMIT) chk(1'b0, "watchdog expired", cyc, LIMIT);
    for (int k = 0; k < NB; k++)
      chk(nwarps[k] == (cnts[k] + WS - 1) / WS, "R5 warps per block", nwarps[k], (cnts[k] + WS - 1) / WS);
    chk(nwarps[0] == 0 && nwarps[6] == 0 && nwarps[7] == 0, "R6 zero blocks", nwarps[0] + nwarps[6] + nwarps[7], 0);
    chk(sig[2] == sig[3], "R9 same shape same split", sig[3], sig[2]);
    chk(overlaps > 0, "R7 same-cycle handoff seen", overlaps, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule